// File: doc/BRIEF.md
# Gate-Drive Fault Supervisor

This block guards a three-phase half-bridge driver. It watches one overcurrent comparator bit and four supply-good bits: one for the low-side supply and one for each of the three floating high-side supplies. From these it produces a global shutdown that turns off all six gate outputs, a per-phase high-side disable, and an active-low fault indication. The fault indication is a drive-low enable, so an external pull-up reads high while no fault is present.

An overcurrent trip only counts once it has been present for a qualifying number of consecutive clock samples. A qualified trip sets a latch that holds the bridge off. The latch is released after a fixed clear interval, timed from the moment the filtered trip has gone away. A low-side undervoltage also forces shutdown and is reported on the same fault output. A high-side undervoltage only disables the high-side switch of its own phase.

There are two state machines. The overcurrent machine has the states OC_IDLE, OC_HOLD and OC_COUNT. Its transitions are: OC_IDLE to OC_HOLD on a filtered trip; OC_HOLD to OC_COUNT when the filtered trip drops; OC_COUNT to OC_HOLD when the filtered trip returns; OC_COUNT to OC_IDLE when the timer expires. The supply machine has the states UV_BOOT, UV_RUN and UV_LOCK. Its transitions are: UV_BOOT to UV_RUN when the low-side supply is good; UV_RUN to UV_LOCK when it is lost; UV_LOCK to UV_RUN when it returns.

Top module: `fault_supervisor`

## Requirements
- R1: A trip input high for fewer than FILTER_CYCLES (default 53) consecutive rising edges causes no shutdown and no fault. Any low sample restarts the qualification. This holds in every state, including during the clear countdown, whose expiry time it does not move.
- R2: A trip input sampled high on FILTER_CYCLES consecutive edges asserts shutdown and fault_drive_low after the edge that follows the qualifying edge, that is after edge FILTER_CYCLES+1 counted from the first high sample.
- R3: While the trip input stays high, shutdown and fault_drive_low stay asserted, however long the trip lasts.
- R4: Count the first rising edge that samples the trip input low as edge 1, and hold the trip input low. Shutdown and fault stay asserted through edge CLEAR_CYCLES+1 (default 6500) and both drop after edge CLEAR_CYCLES+2.
- R5: A qualified trip during the clear countdown restarts the interval. The latch then clears CLEAR_CYCLES+2 edges after the new release, regardless of the earlier release.
- R6: Once the low-side supply has been good, its loss asserts shutdown and fault_drive_low one edge later. Its return releases both one edge later, provided no overcurrent latch is set.
- R7: After reset, shutdown is 1, fault_drive_low is 0 and hs_disable is all ones. Shutdown stays 1 until ls_supply_ok is sampled 1.
- R8: hs_supply_ok[i] = 0 sets hs_disable[i] = 1 one edge later. The other phases, shutdown and fault_drive_low are not affected.
- R9: fault_drive_low is the OR of the overcurrent latch and the low-side lockout. Loss or return of the supply neither sets nor clears the overcurrent latch, and fault stays asserted until both causes are gone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (100 MHz for the default timings) |
| rst_n | input | 1 | Asynchronous active-low reset |
| trip_in | input | 1 | Overcurrent comparator output, 1 = over threshold |
| ls_supply_ok | input | 1 | Low-side supply above its lockout threshold |
| hs_supply_ok | input | PHASES (3) | Per-phase high-side supply good |
| shutdown | output | 1 | 1 = all six gate outputs off |
| hs_disable | output | PHASES (3) | 1 = high-side switch of that phase off |
| fault_drive_low | output | 1 | 1 = pull the fault line low |

## Verification
Suppose the overcurrent machine sits in the wrong state, or its timer is off by one. That shows as shutdown rising or falling one or more edges away from the expected edge. So the bench samples exactly on the edge before and the edge after each expected change. A stuck filter counter shows either as a sub-threshold burst that latches, or as a qualifying burst that does not latch, within FILTER_CYCLES+1 edges. A supply machine error is visible one edge after the supply input changes, both on shutdown and on the fault line.

// File: rtl/fs_pkg.sv
package fs_pkg;
    typedef enum logic [1:0] {
        OC_IDLE  = 2'd0,
        OC_HOLD  = 2'd1,
        OC_COUNT = 2'd2
    } oc_state_t;

    typedef enum logic [1:0] {
        UV_BOOT = 2'd0,
        UV_RUN  = 2'd1,
        UV_LOCK = 2'd2
    } uv_state_t;
endpackage

// File: rtl/fs_trip_filter.sv
module fs_trip_filter #(
    parameter int FILTER_CYCLES = 53
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trip_in,
    output logic trip_filt
);
    localparam int CW = $clog2(FILTER_CYCLES + 1);
    localparam logic [CW-1:0] CNT_LAST = CW'(FILTER_CYCLES - 1);

    logic [CW-1:0] run_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_cnt   <= '0;
            trip_filt <= 1'b0;
        end else if (!trip_in) begin
            run_cnt   <= '0;
            trip_filt <= 1'b0;
        end else if (run_cnt == CNT_LAST) begin
            trip_filt <= 1'b1;
        end else begin
            run_cnt <= run_cnt + 1'b1;
        end
    end

    // R1: a low sample always drops the qualified trip
    a_r1_release: assert property (@(posedge clk) disable iff (!rst_n)
        !trip_in |=> !trip_filt);
    // R1: a qualified trip only rises after a high sample
    a_r1_rise_needs_trip: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(trip_filt) |-> $past(trip_in));
endmodule

// File: rtl/fs_oc_fsm.sv
module fs_oc_fsm
    import fs_pkg::*;
#(
    parameter int CLEAR_CYCLES = 6500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trip_filt,
    output logic oc_latched
);
    localparam int TW = $clog2(CLEAR_CYCLES + 1);
    localparam logic [TW-1:0] TMR_LAST = TW'(CLEAR_CYCLES - 1);

    oc_state_t     state, state_nx;
    logic [TW-1:0] clr_tmr;

    always_comb begin
        state_nx = state;
        unique case (state)
            OC_IDLE:  if (trip_filt) state_nx = OC_HOLD;
            OC_HOLD:  if (!trip_filt) state_nx = OC_COUNT;
            OC_COUNT: begin
                if (trip_filt)                 state_nx = OC_HOLD;
                else if (clr_tmr == TMR_LAST)  state_nx = OC_IDLE;
            end
            default:  state_nx = OC_HOLD;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= OC_IDLE;
            clr_tmr <= '0;
        end else begin
            state <= state_nx;
            if (state_nx == OC_COUNT && state == OC_COUNT)
                clr_tmr <= clr_tmr + 1'b1;
            else
                clr_tmr <= '0;
        end
    end

    always_comb begin
        oc_latched = (state != OC_IDLE);
    end

    // R2: a qualified trip sets the latch on the next edge
    a_r2_latch_sets: assert property (@(posedge clk) disable iff (!rst_n)
        trip_filt |=> oc_latched);
    // R3: the latch never drops while the trip is still qualified
    a_r3_no_clear_in_trip: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(oc_latched) |-> !$past(trip_filt));
    // R4: the clear timer never runs past its last value
    a_r4_timer_bound: assert property (@(posedge clk) disable iff (!rst_n)
        clr_tmr <= TMR_LAST);
endmodule

// File: rtl/fs_supply_mon.sv
module fs_supply_mon
    import fs_pkg::*;
#(
    parameter int PHASES = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ls_supply_ok,
    input  logic [PHASES-1:0] hs_supply_ok,
    output logic              uv_shutdown,
    output logic              uv_fault,
    output logic [PHASES-1:0] hs_disable
);
    uv_state_t state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            UV_BOOT: if (ls_supply_ok)  state_nx = UV_RUN;
            UV_RUN:  if (!ls_supply_ok) state_nx = UV_LOCK;
            UV_LOCK: if (ls_supply_ok)  state_nx = UV_RUN;
            default: state_nx = UV_BOOT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= UV_BOOT;
        else        state <= state_nx;
    end

    always_comb begin
        uv_shutdown = (state != UV_RUN);
        uv_fault    = (state == UV_LOCK);
    end

    for (genvar p = 0; p < PHASES; p++) begin : g_hs
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) hs_disable[p] <= 1'b1;
            else        hs_disable[p] <= !hs_supply_ok[p];
        end
        // R8: a bad floating supply disables its own high side
        a_r8_hs_off: assert property (@(posedge clk) disable iff (!rst_n)
            !hs_supply_ok[p] |=> hs_disable[p]);
    end

    // R6: loss of the low-side supply forces shutdown next edge
    a_r6_uv_off: assert property (@(posedge clk) disable iff (!rst_n)
        !ls_supply_ok |=> uv_shutdown);
    // R7: leaving boot requires a good low-side sample
    a_r7_boot_exit: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(uv_shutdown) |-> $past(ls_supply_ok));
endmodule

// File: rtl/fault_supervisor.sv
module fault_supervisor #(
    parameter int FILTER_CYCLES = 53,
    parameter int CLEAR_CYCLES  = 6500,
    parameter int PHASES        = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trip_in,
    input  logic              ls_supply_ok,
    input  logic [PHASES-1:0] hs_supply_ok,
    output logic              shutdown,
    output logic [PHASES-1:0] hs_disable,
    output logic              fault_drive_low
);
    logic trip_filt;
    logic oc_latched;
    logic uv_shutdown;
    logic uv_fault;

    fs_trip_filter #(.FILTER_CYCLES(FILTER_CYCLES)) u_filter (
        .clk       (clk),
        .rst_n     (rst_n),
        .trip_in   (trip_in),
        .trip_filt (trip_filt)
    );

    fs_oc_fsm #(.CLEAR_CYCLES(CLEAR_CYCLES)) u_oc (
        .clk        (clk),
        .rst_n      (rst_n),
        .trip_filt  (trip_filt),
        .oc_latched (oc_latched)
    );

    fs_supply_mon #(.PHASES(PHASES)) u_supply (
        .clk          (clk),
        .rst_n        (rst_n),
        .ls_supply_ok (ls_supply_ok),
        .hs_supply_ok (hs_supply_ok),
        .uv_shutdown  (uv_shutdown),
        .uv_fault     (uv_fault),
        .hs_disable   (hs_disable)
    );

    always_comb begin
        shutdown        = oc_latched | uv_shutdown;
        fault_drive_low = oc_latched | uv_fault;
    end

    // R9: an overcurrent latch always shows on the fault line
    a_r9_oc_fault: assert property (@(posedge clk) disable iff (!rst_n)
        oc_latched |-> fault_drive_low);
    // R2: the fault line is never active without shutdown
    a_r2_fault_implies_off: assert property (@(posedge clk) disable iff (!rst_n)
        fault_drive_low |-> shutdown);
endmodule

// File: tb/fault_supervisor_test.sv
module fault_supervisor_test;
    localparam int CLK_PERIOD = 10;
    localparam int FILT  = 53;
    localparam int CLR   = 6500;
    localparam int PH    = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          trip_in = 1'b0;
    logic          ls_supply_ok = 1'b0;
    logic [PH-1:0] hs_supply_ok = '0;
    logic          shutdown;
    logic [PH-1:0] hs_disable;
    logic          fault_drive_low;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    fault_supervisor #(.FILTER_CYCLES(FILT), .CLEAR_CYCLES(CLR), .PHASES(PH)) uut (
        .clk             (clk),
        .rst_n           (rst_n),
        .trip_in         (trip_in),
        .ls_supply_ok    (ls_supply_ok),
        .hs_supply_ok    (hs_supply_ok),
        .shutdown        (shutdown),
        .hs_disable      (hs_disable),
        .fault_drive_low (fault_drive_low)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic chk_out(input string req, input int sd, input int flt);
        check(req, "shutdown", int'(shutdown), sd);
        check(req, "fault_drive_low", int'(fault_drive_low), flt);
    endtask

    task automatic t_reset;
        tick(2);
        rst_n = 1'b1;
        tick(3);
        chk_out("R7", 1, 0);
        check("R7", "hs_disable", int'(hs_disable), 7);
        ls_supply_ok = 1'b1;
        hs_supply_ok = '1;
        tick(1);
        chk_out("R7", 0, 0);
        check("R7", "hs_disable", int'(hs_disable), 0);
    endtask

    task automatic t_short_pulse;
        trip_in = 1'b1; tick(FILT - 1);
        trip_in = 1'b0; tick(1);
        trip_in = 1'b1; tick(FILT - 1);
        trip_in = 1'b0; tick(3);
        chk_out("R1", 0, 0);
    endtask

    task automatic t_latch_hold;
        trip_in = 1'b1;
        tick(FILT);
        chk_out("R2", 0, 0);
        tick(1);
        chk_out("R2", 1, 1);
        tick(CLR + 3000);
        chk_out("R3", 1, 1);
    endtask

    task automatic t_clear;
        trip_in = 1'b0;
        tick(200);
        trip_in = 1'b1; tick(FILT - 1);   // R1: sub-filter burst inside countdown
        trip_in = 1'b0;
        tick(CLR + 1 - 200 - (FILT - 1));
        chk_out("R4", 1, 1);
        tick(1);
        chk_out("R4", 0, 0);
    endtask

    task automatic t_retrip;
        trip_in = 1'b1; tick(FILT + 1);
        chk_out("R2", 1, 1);
        trip_in = 1'b0; tick(100);
        trip_in = 1'b1; tick(FILT + 5);
        trip_in = 1'b0;
        tick(CLR + 1);
        chk_out("R5", 1, 1);
        tick(1);
        chk_out("R5", 0, 0);
    endtask

    task automatic t_uv;
        ls_supply_ok = 1'b0; tick(1);
        chk_out("R6", 1, 1);
        ls_supply_ok = 1'b1; tick(1);
        chk_out("R6", 0, 0);
    endtask

    task automatic t_hs;
        hs_supply_ok = 3'b101; tick(1);
        check("R8", "hs_disable", int'(hs_disable), 2);
        chk_out("R8", 0, 0);
        hs_supply_ok = 3'b011; tick(1);
        check("R8", "hs_disable", int'(hs_disable), 4);
        hs_supply_ok = '1; tick(1);
        check("R8", "hs_disable", int'(hs_disable), 0);
    endtask

    task automatic t_combined;
        trip_in = 1'b1; tick(FILT + 1);
        ls_supply_ok = 1'b0; tick(1);
        ls_supply_ok = 1'b1; tick(1);
        chk_out("R9", 1, 1);
        trip_in = 1'b0;
        ls_supply_ok = 1'b0;
        tick(CLR + 2);
        chk_out("R9", 1, 1);
        ls_supply_ok = 1'b1; tick(1);
        chk_out("R9", 0, 0);
    endtask

    initial begin
        t_reset();
        t_short_pulse();
        t_latch_hold();
        t_clear();
        t_retrip();
        t_uv();
        t_hs();
        t_combined();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule